// File: doc/BRIEF.md
# Four-Phase Control Register Bus Master

This block drives a parallel control-register bus of the kind used to reach the internal configuration registers of a serial PHY. A host hands it one read or write command at a time over a valid/ready command port. The master then works through a fixed series of phases on the bus. Each phase places an operand on a shared 16-bit data-in field, raises one strobe, and completes a full four-phase handshake with the PHY's acknowledge line.

A write uses three phases in a fixed order: capture the address, capture the data, then the write strobe. A read uses an address capture followed by a read strobe, with the data-in field cleared to zero. The PHY's data-out value is taken in the cycle that acknowledge is first seen high during the read strobe. Every wait for acknowledge is bounded by a cycle count. When that count runs out, the transaction is abandoned and reported as failed.

The command port follows valid/ready rules. `cmd_ready` is high exactly when the master is idle. A command transfers in a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the values on `cmd_valid` and the command fields have no effect. The result port is not back-pressured. `rsp_done` is a one-cycle pulse, and `rsp_rdata` holds its value until the next successful read.

Top module: `cr_bus_master`

## Requirements
- R1: A synchronous active-high reset, applied in any state, returns the master to idle on the next edge. After that edge the control word is zero, busy is low, the done and error pulses are low and the read-data register is zero.
- R2: The 20-bit control word has fixed bit positions. Bit 0 is the write strobe and bit 1 is the read strobe. Bits 17..2 hold data-in. Bit 18 is the data-capture strobe and bit 19 is the address-capture strobe. At most one strobe is high at any time.
- R3: `cmd_ready` equals the inverse of `busy`. A command is accepted on an edge where `cmd_valid` and `cmd_ready` are both high. Busy is high from the next cycle up to, but not including, the cycle in which the done pulse is shown.
- R4: Every phase starts with SETUP_CYC cycles in which its operand is on data-in and all strobes are low. The strobe for that phase rises only after those cycles.
- R5: A raised strobe stays high until acknowledge is sampled high. The strobe then drops in the next cycle with data-in unchanged. The next phase, or completion, follows only once acknowledge is sampled low.
- R6: A write performs three phases in order. The first is address capture with the address on data-in. The second is data capture with the write data on data-in. The third is the write strobe with the write data on data-in.
- R7: A read performs address capture, then a read-strobe phase with data-in at zero. The read-data output takes the data-out value sampled in the cycle that acknowledge is first seen high during the read strobe. It shows that value from the next cycle and holds it until the next successful read.
- R8: Each acknowledge wait, both for the rise and for the fall, may last at most TIMEOUT_CYC cycles. If acknowledge arrives in the last allowed cycle, the transaction proceeds. If it does not, the master returns to idle with the control word at zero and pulses done and error together in the following cycle.
- R9: A transaction that completes without timeout gives a one-cycle done pulse with error low. The pulse comes in the cycle after acknowledge is sampled low at the end of the final phase.
- R10: Commands presented while busy are ignored. No extra phase runs after the current transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle and able to take a command |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | DATA_W | Register address |
| cmd_wdata | input | DATA_W | Write data (ignored for reads) |
| busy | output | 1 | Transaction in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | High with rsp_done when a wait timed out |
| rsp_rdata | output | DATA_W | Last successfully read value |
| cr_ctl | output | DATA_W+4 | Control word: strobes and data-in field |
| cr_ack | input | 1 | Acknowledge from the register bus slave |
| cr_dout | input | DATA_W | Data-out from the register bus slave |

## Verification
The bench tests the timeout boundary by placing an acknowledge exactly in the last allowed cycle and then one cycle later. A master whose counter is off by one would fail the first of these transactions or let the second one pass. Separate runs hold acknowledge high after the strobe drops and keep it low after the strobe rises, so a master that skips waiting for the falling edge would begin the next phase early. The slave model drives a wrong data-out value whenever acknowledge is low, so sampling read data in any cycle other than the first acknowledged one returns the wrong value. Commands are also sent while the master is busy, and a reset is applied in the middle of a transaction, to catch a master that queues a command or leaves a strobe hanging.

// File: rtl/cr_bus_pkg.sv
package cr_bus_pkg;

  // Fixed positions of the low strobes and the start of the data-in field.
  localparam int WR_POS  = 0;
  localparam int RD_POS  = 1;
  localparam int DIN_POS = 2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_t;

endpackage

// File: rtl/cr_down_cnt.sv
module cr_down_cnt #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CW'(LIMIT);
    else if (en && (cnt_q != '0))
      cnt_q <= cnt_q - CW'(1);
  end

  // High in the final permitted cycle of the window.
  assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/cr_phase_seq.sv
module cr_phase_seq
  import cr_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       is_write,
  input  logic       ack,
  input  logic       setup_last,
  input  logic       wait_last,
  output seq_state_t state_q,
  output phase_t     phase_q,
  output logic       setup_load,
  output logic       wait_load,
  output logic       rd_sample,
  output logic       finish,
  output logic       fail
);
  seq_state_t state_d;
  phase_t     phase_d;

  always_comb begin
    state_d    = state_q;
    phase_d    = phase_q;
    setup_load = 1'b0;
    wait_load  = 1'b0;
    rd_sample  = 1'b0;
    finish     = 1'b0;
    fail       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d    = ST_SETUP;
          phase_d    = PH_ADDR;
          setup_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (setup_last) begin
          state_d   = ST_STROBE;
          wait_load = 1'b1;
        end
      end
      ST_STROBE: begin
        if (ack) begin
          state_d   = ST_RELEASE;
          wait_load = 1'b1;
          rd_sample = (phase_q == PH_READ);
        end else if (wait_last) begin
          state_d = ST_IDLE;
          fail    = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (!ack) begin
          unique case (phase_q)
            PH_ADDR: begin
              state_d    = ST_SETUP;
              phase_d    = is_write ? PH_DATA : PH_READ;
              setup_load = 1'b1;
            end
            PH_DATA: begin
              state_d    = ST_SETUP;
              phase_d    = PH_WRITE;
              setup_load = 1'b1;
            end
            default: begin
              state_d = ST_IDLE;
              finish  = 1'b1;
            end
          endcase
        end else if (wait_last) begin
          state_d = ST_IDLE;
          fail    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADDR;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/cr_word_drive.sv
module cr_word_drive
  import cr_bus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  seq_state_t          state,
  input  phase_t              phase,
  input  logic [DATA_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W+3:0]   word
);
  localparam int CAPD_POS = DIN_POS + DATA_W;
  localparam int CAPA_POS = CAPD_POS + 1;

  logic [DATA_W-1:0] operand;
  logic              strobe_on;

  always_comb begin
    unique case (phase)
      PH_ADDR:           operand = addr;
      PH_DATA, PH_WRITE: operand = wdata;
      default:           operand = '0;
    endcase
  end

  assign strobe_on = (state == ST_STROBE);

  always_comb begin
    word = '0;
    if (state != ST_IDLE) begin
      word[DIN_POS +: DATA_W] = operand;
      if (strobe_on) begin
        unique case (phase)
          PH_ADDR:  word[CAPA_POS] = 1'b1;
          PH_DATA:  word[CAPD_POS] = 1'b1;
          PH_WRITE: word[WR_POS]   = 1'b1;
          default:  word[RD_POS]   = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/cr_bus_master.sv
module cr_bus_master
  import cr_bus_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SETUP_CYC   = 2,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W+3:0] cr_ctl,
  input  logic              cr_ack,
  input  logic [DATA_W-1:0] cr_dout
);
  seq_state_t        state;
  phase_t            phase;
  logic              start;
  logic              setup_load, wait_load, setup_last, wait_last;
  logic              rd_sample, finish, fail;
  logic              write_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic              done_q, err_q;

  assign busy      = (state != ST_IDLE);
  assign cmd_ready = !busy;
  assign start     = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      write_q <= cmd_write;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_wdata;
    end
  end

  cr_phase_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .is_write   (write_q),
    .ack        (cr_ack),
    .setup_last (setup_last),
    .wait_last  (wait_last),
    .state_q    (state),
    .phase_q    (phase),
    .setup_load (setup_load),
    .wait_load  (wait_load),
    .rd_sample  (rd_sample),
    .finish     (finish),
    .fail       (fail)
  );

  cr_down_cnt #(.LIMIT(SETUP_CYC)) u_setup_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (setup_load),
    .en   (state == ST_SETUP),
    .last (setup_last)
  );

  cr_down_cnt #(.LIMIT(TIMEOUT_CYC)) u_wait_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (wait_load),
    .en   ((state == ST_STROBE) || (state == ST_RELEASE)),
    .last (wait_last)
  );

  cr_word_drive #(.DATA_W(DATA_W)) u_word (
    .state (state),
    .phase (phase),
    .addr  (addr_q),
    .wdata (wdata_q),
    .word  (cr_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (rd_sample)
        rdata_q <= cr_dout;
      done_q <= finish || fail;
      err_q  <= fail;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/cr_bus_master_chk.sv
module cr_bus_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic [DATA_W+3:0] cr_ctl
);
  logic [3:0]        stb;
  logic [DATA_W-1:0] din;

  assign stb = {cr_ctl[DATA_W+3], cr_ctl[DATA_W+2], cr_ctl[1], cr_ctl[0]};
  assign din = cr_ctl[2 +: DATA_W];

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cr_ctl == '0)); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy); // R3

  AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(|stb) |-> $stable(din)); // R4

  AST_DIN_HELD_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    ($fell(|stb) && busy) |-> $stable(din)); // R5

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_done); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R9
endmodule

bind cr_bus_master cr_bus_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .cr_ctl    (cr_ctl)
);

// File: tb/cr_bus_master_bench.sv
module cr_bus_master_bench;
  localparam int DW   = 16;
  localparam int SU   = 2;
  localparam int TO   = 12;
  localparam int MAXC = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [DW-1:0] cmd_addr = '0, cmd_wdata = '0;
  logic          cmd_ready, busy, rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [DW+3:0] cr_ctl;
  logic          cr_ack = 1'b0;
  logic [DW-1:0] cr_dout;

  always #10 clk = ~clk; // 50 MHz

  cr_bus_master #(.DATA_W(DW), .SETUP_CYC(SU), .TIMEOUT_CYC(TO)) u_cr_bus_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cr_ctl(cr_ctl), .cr_ack(cr_ack), .cr_dout(cr_dout)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- slave responder ----------------
  int            rise_d = 1, fall_d = 1, rcnt = 0;
  bit            mute = 0, stuck = 0;
  logic [DW-1:0] rd_val = 16'h0000;
  assign cr_dout = cr_ack ? rd_val : 16'h0BAD;

  always @(negedge clk) begin
    logic stbv;
    stbv = cr_ctl[19] | cr_ctl[18] | cr_ctl[1] | cr_ctl[0];
    if (rst) begin
      cr_ack = 1'b0; rcnt = 0;
    end else if (stbv && !cr_ack) begin
      rcnt++;
      if (!mute && rcnt >= rise_d) begin cr_ack = 1'b1; rcnt = 0; end
    end else if (!stbv && cr_ack) begin
      rcnt++;
      if (!stuck && rcnt >= fall_d) begin cr_ack = 1'b0; rcnt = 0; end
    end else rcnt = 0;
  end

  // ---------------- strobe log ----------------
  logic [DW+3:0] log_q[$];
  logic [3:0]    prev_stb = '0;
  always @(negedge clk) begin
    logic [3:0] s;
    s = {cr_ctl[19], cr_ctl[18], cr_ctl[1], cr_ctl[0]};
    if (s != 4'd0 && prev_stb == 4'd0) log_q.push_back(cr_ctl);
    prev_stb = s;
  end

  // ---------------- reference model ----------------
  int            m_st = 0, m_ph = 0, m_cnt = 0, m_wait = 0;
  bit            m_wr = 0, started = 0;
  logic [DW-1:0] m_addr = '0, m_wd = '0, e_rd = '0;
  bit            e_done = 0, e_err = 0;

  function automatic logic [DW+3:0] exp_word();
    logic [DW+3:0] w;
    logic [DW-1:0] op;
    w = '0;
    if (m_st == 0) return w;
    op = (m_ph == 0) ? m_addr : (m_ph == 3) ? '0 : m_wd;
    w[17:2] = op;
    if (m_st == 2) begin
      case (m_ph)
        0: w[19] = 1'b1;
        1: w[18] = 1'b1;
        2: w[0]  = 1'b1;
        default: w[1] = 1'b1;
      endcase
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      started = 1; m_st = 0; m_ph = 0; e_done = 0; e_err = 0; e_rd = '0;
    end else begin
      e_done = 0; e_err = 0;
      case (m_st)
        0: if (cmd_valid) begin
             m_wr = cmd_write; m_addr = cmd_addr; m_wd = cmd_wdata;
             m_st = 1; m_ph = 0; m_cnt = SU;
           end
        1: begin
             m_cnt--;
             if (m_cnt == 0) begin m_st = 2; m_wait = 0; end
           end
        2: begin
             m_wait++;
             if (cr_ack) begin
               if (m_ph == 3) e_rd = cr_dout;
               m_st = 3; m_wait = 0;
             end else if (m_wait == TO) begin
               m_st = 0; e_done = 1; e_err = 1;
             end
           end
        default: begin
             m_wait++;
             if (!cr_ack) begin
               if (m_ph == 0) begin m_ph = m_wr ? 1 : 3; m_st = 1; m_cnt = SU; end
               else if (m_ph == 1) begin m_ph = 2; m_st = 1; m_cnt = SU; end
               else begin m_st = 0; e_done = 1; end
             end else if (m_wait == TO) begin
               m_st = 0; e_done = 1; e_err = 1;
             end
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R2/R4/R5/R6 per-cycle control word", 32'(cr_ctl), 32'(exp_word()));
      chk("R3 per-cycle busy", 32'(busy), 32'(m_st != 0));
      chk("R3 per-cycle ready", 32'(cmd_ready), 32'(m_st == 0));
      chk("R9 per-cycle done", 32'(rsp_done), 32'(e_done));
      chk("R8 per-cycle err", 32'(rsp_err), 32'(e_err));
      chk("R7 per-cycle rdata", 32'(rsp_rdata), 32'(e_rd));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > MAXC) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, MAXC);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit wr, logic [DW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit err);
    err = 0;
    for (int i = 0; i < 400; i++) begin
      if (rsp_done) begin err = rsp_err; return; end
      @(negedge clk);
    end
    chk("R9 done seen", 32'd0, 32'd1);
  endtask

  initial begin
    bit e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ctl after reset", 32'(cr_ctl), 32'd0);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 rdata after reset", 32'(rsp_rdata), 32'd0);
    chk("R1 done after reset", 32'(rsp_done), 32'd0);

    // R6 write, with R2 field positions
    log_q.delete();
    issue(1'b1, 16'h1234, 16'hBEEF);
    chk("R3 busy after accept", 32'(busy), 32'd1);
    chk("R3 ready low while busy", 32'(cmd_ready), 32'd0);
    wait_done(e);
    chk("R9 write ok", 32'(e), 32'd0);
    chk("R3 busy low in done cycle", 32'(busy), 32'd0);
    chk("R6 phase count", 32'(log_q.size()), 32'd3);
    if (log_q.size() == 3) begin
      chk("R2 R6 addr capture word", 32'(log_q[0]), (32'd1 << 19) | (32'h1234 << 2));
      chk("R2 R6 data capture word", 32'(log_q[1]), (32'd1 << 18) | (32'hBEEF << 2));
      chk("R2 R6 write strobe word", 32'(log_q[2]), (32'hBEEF << 2) | 32'd1);
    end

    // R7 read with slower slave
    rise_d = 3; fall_d = 2; rd_val = 16'h5A5A;
    log_q.delete();
    issue(1'b0, 16'h0042, 16'hFFFF);
    wait_done(e);
    chk("R7 read ok", 32'(e), 32'd0);
    @(negedge clk);
    chk("R7 read data", 32'(rsp_rdata), 32'h5A5A);
    chk("R7 phase count", 32'(log_q.size()), 32'd2);
    if (log_q.size() == 2) begin
      chk("R7 addr word", 32'(log_q[0]), (32'd1 << 19) | (32'h0042 << 2));
      chk("R2 R7 read strobe word zero din", 32'(log_q[1]), 32'd2);
    end

    // R8 boundary: ack in the final allowed cycle
    rise_d = TO; fall_d = 1; rd_val = 16'hC3C3;
    issue(1'b0, 16'h0007, 16'h0);
    wait_done(e);
    chk("R8 ack on last cycle succeeds", 32'(e), 32'd0);
    @(negedge clk);
    chk("R8 read at boundary", 32'(rsp_rdata), 32'hC3C3);

    // R8 one cycle too late: fails, rdata kept
    rise_d = TO + 1; rd_val = 16'h1111;
    issue(1'b0, 16'h0008, 16'h0);
    wait_done(e);
    chk("R8 late ack times out", 32'(e), 32'd1);
    chk("R8 word zero on timeout", 32'(cr_ctl), 32'd0);
    @(negedge clk);
    chk("R7 rdata held after failure", 32'(rsp_rdata), 32'hC3C3);
    repeat (4) @(negedge clk);

    // R8 mute slave
    rise_d = 1; mute = 1;
    issue(1'b1, 16'h0100, 16'h0200);
    wait_done(e);
    chk("R8 no ack rise", 32'(e), 32'd1);
    mute = 0;
    repeat (3) @(negedge clk);

    // R5 R8 acknowledge stuck high after the strobe drops
    stuck = 1;
    issue(1'b1, 16'h0300, 16'h0400);
    wait_done(e);
    chk("R5 R8 ack never falls", 32'(e), 32'd1);
    stuck = 0;
    repeat (4) @(negedge clk);
    chk("R5 slave ack released", 32'(cr_ack), 32'd0);

    // R10 commands during busy are ignored
    log_q.delete();
    issue(1'b1, 16'h0AAA, 16'h0555);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 16'h7777;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(e);
    chk("R10 first command ok", 32'(e), 32'd0);
    repeat (6) @(negedge clk);
    chk("R10 no extra transaction busy", 32'(busy), 32'd0);
    chk("R10 only three phases", 32'(log_q.size()), 32'd3);

    // R1 reset mid-transaction
    issue(1'b1, 16'h0F0F, 16'hF0F0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ctl zero after mid reset", 32'(cr_ctl), 32'd0);
    chk("R1 busy low after mid reset", 32'(busy), 32'd0);
    chk("R1 rdata cleared", 32'(rsp_rdata), 32'd0);
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule